// File: doc/BRIEF.md
# Dual-Clock FIFO with Status Flags

This block moves data words from one clock domain to another. A producer writes on its own clock and watches a full flag and an almost-full flag. A consumer reads on an unrelated clock and watches an empty flag and an almost-empty flag. A write refused because the buffer is full raises a one-cycle write error pulse. A read refused because nothing is available raises a one-cycle read error pulse. Both are one clock cycle wide in their own domain.

Each side keeps a binary position counter one bit wider than the storage address. Each side publishes a Gray-coded copy of its counter, and the other side picks it up through two flip-flop stages. Every flag is computed in its own domain from the local counter and the synchronised counter of the other side. A flag therefore clears only after the other side's progress has crossed over. It never clears early.

A build-time parameter selects one of two read styles. In registered mode, a granted read loads the output register at the read-clock edge, so the word shows up after that edge. In look-ahead mode, the oldest word is loaded into the output register before anyone asks for it. The consumer sees that word whenever empty is low, and asserting the read enable removes it. That output register adds one word of capacity.

Top module: `dcfifo_flags`

## Requirements
- R1: While `arst` is high and right after it falls: `rd_empty`=1, `rd_aempty`=1, `wr_full`=0, `wr_afull`=0, `wr_err`=0, `rd_err`=0, `rd_data`=0.
- R2: Registered mode. If `rd_en` is high at a read-clock edge while `rd_empty` is low, the oldest stored word is on `rd_data` after that same edge.
- R3: Look-ahead mode. While `rd_empty` is low, `rd_data` already holds the oldest unread word. Asserting `rd_en` for one edge consumes it, and the next word, if any, takes its place.
- R4: When the last stored word is consumed, `rd_empty` rises. In registered mode it rises at the very edge that puts that last word on `rd_data`, and the word stays there.
- R5: Once both sides have settled, `rd_aempty` is high exactly when the number of unread words, counting the look-ahead output word, is at most `AE_LEVEL`. It updates at the read edge that changes that number.
- R6: Once both sides have settled, `wr_full` is high exactly when the storage array holds 2^`ADDR_W` words, and `wr_afull` is high exactly when it holds at least 2^`ADDR_W` − `AF_LEVEL`. Total capacity is 2^`ADDR_W` words in registered mode and 2^`ADDR_W`+1 in look-ahead mode.
- R7: A write attempted while `wr_full` is high raises `wr_err` for one write-clock cycle. The data is discarded and the write position does not move.
- R8: A read attempted while `rd_empty` is high raises `rd_err` for one read-clock cycle. Nothing is consumed, and in registered mode `rd_data` keeps its value.
- R9: If the FIFO is empty and a read follows a write within two read-clock edges, the read is refused with `rd_err`, `rd_empty` stays high, and the word is delivered by a later read.
- R10: A word written into an empty FIFO makes `rd_empty` fall at the third rising read-clock edge after the write edge, in both modes.
- R11: Words come out in the order they were accepted across many wraps of the position counters, under concurrent traffic at both a fast and a slow read rate. The published write position changes by at most one bit per write-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| arst | input | 1 | Asynchronous reset, active high, both domains |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Storage array full |
| wr_afull | output | 1 | Free space at or below AF_LEVEL |
| wr_err | output | 1 | Pulse: write refused |
| rd_en | input | 1 | Read request (consume in look-ahead mode) |
| rd_data | output | DATA_W | Read word |
| rd_empty | output | 1 | No word available |
| rd_aempty | output | 1 | Unread words at or below AE_LEVEL |
| rd_err | output | 1 | Pulse: read refused |

## Verification
The bench fills each variant of an eight-entry configuration one word at a time, checks all four flags after every step, and then drains it the same way. An off-by-one in the level arithmetic shows up as a flag changing one word early or late. A design that ignored the full flag would overwrite the oldest word, and the discarded overflow word would then appear in the drained sequence. It also fires a read right after a write into an empty FIFO. A design that bypassed synchronisation would serve that read, and a design with extra sync stages would miss the three-edge latency of R10. Long concurrent runs at two read rates catch Gray or wrap errors as reordered or repeated words. In look-ahead mode they also catch a mishandled output stage, which shows up as a lost or duplicated head word.

// File: rtl/dcf_pkg.sv
`timescale 1ns/100ps
package dcf_pkg;

  typedef enum logic {RD_STANDARD = 1'b0, RD_FWFT = 1'b1} rd_mode_e;

  // Position values are carried zero-extended in this width.
  typedef logic [15:0] ptr_t;

  function automatic ptr_t gray_to_bin(ptr_t g);
    ptr_t b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Distance from tail to head modulo 2^pw.
  function automatic ptr_t span(ptr_t head, ptr_t tail, int unsigned pw);
    return (head - tail) & ((ptr_t'(1) << pw) - ptr_t'(1));
  endfunction

endpackage

// File: rtl/dcf_sync2.sv
`timescale 1ns/100ps
module dcf_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         arst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/100ps
module dcf_wr_side import dcf_pkg::*; #(
  parameter int ADDR_W   = 4,
  parameter int AF_LEVEL = 2
) (
  input  logic              clk,
  input  logic              arst,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic [ADDR_W:0]   wgray,
  output logic [ADDR_W-1:0] waddr,
  output logic              wr_go,
  output logic              full,
  output logic              afull,
  output logic              wr_err,
  output ptr_t              level
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W:0] wbin, wbin_nxt;
  ptr_t            rbin_s, level_nxt;

  always_comb begin
    rbin_s    = gray_to_bin(ptr_t'(rgray_sync));
    wr_go     = wr_en & ~full;
    wbin_nxt  = wbin + {{ADDR_W{1'b0}}, wr_go};
    level_nxt = span(ptr_t'(wbin_nxt), rbin_s, PW);
    level     = span(ptr_t'(wbin), rbin_s, PW);
  end

  assign waddr = wbin[ADDR_W-1:0];

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      wbin   <= '0;
      wgray  <= '0;
      full   <= 1'b0;
      afull  <= 1'b0;
      wr_err <= 1'b0;
    end else begin
      wbin   <= wbin_nxt;
      wgray  <= wbin_nxt ^ (wbin_nxt >> 1);
      full   <= (level_nxt == ptr_t'(DEPTH));
      afull  <= (level_nxt >= ptr_t'(DEPTH - AF_LEVEL));
      wr_err <= wr_en & full;
    end
  end
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/100ps
module dcf_rd_side import dcf_pkg::*; #(
  parameter int       DATA_W    = 8,
  parameter int       ADDR_W    = 4,
  parameter int       AE_LEVEL  = 2,
  parameter rd_mode_e READ_MODE = RD_STANDARD
) (
  input  logic              clk,
  input  logic              arst,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   wgray_sync,
  input  logic [DATA_W-1:0] mem_q,
  output logic [ADDR_W:0]   rgray,
  output logic [ADDR_W-1:0] raddr,
  output logic              rd_take,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              aempty,
  output logic              rd_err
);
  localparam int PW = ADDR_W + 1;

  logic [ADDR_W:0] rbin, rbin_nxt;
  ptr_t            wbin_s;
  logic            advance, empty_nxt, aempty_nxt;

  assign wbin_s  = gray_to_bin(ptr_t'(wgray_sync));
  assign rd_take = rd_en & ~empty;
  assign raddr   = rbin[ADDR_W-1:0];
  assign rbin_nxt = rbin + {{ADDR_W{1'b0}}, advance};

  generate
    if (READ_MODE == RD_STANDARD) begin : g_registered
      ptr_t left_nxt;
      always_comb begin
        advance    = rd_take;
        left_nxt   = span(wbin_s, ptr_t'(rbin_nxt), PW);
        empty_nxt  = (left_nxt == '0);
        aempty_nxt = (left_nxt <= ptr_t'(AE_LEVEL));
      end
    end else begin : g_lookahead
      // The output register is a one-word stage; it holds a word when empty is low.
      logic stage_nxt, have_stored;
      ptr_t left_nxt;
      always_comb begin
        have_stored = (span(wbin_s, ptr_t'(rbin), PW) != '0);
        advance     = have_stored & (empty | rd_take);
        stage_nxt   = advance | (~empty & ~rd_take);
        left_nxt    = span(wbin_s, ptr_t'(rbin_nxt), PW) + ptr_t'(stage_nxt);
        empty_nxt   = ~stage_nxt;
        aempty_nxt  = (left_nxt <= ptr_t'(AE_LEVEL));
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      rbin    <= '0;
      rgray   <= '0;
      rd_data <= '0;
      empty   <= 1'b1;
      aempty  <= 1'b1;
      rd_err  <= 1'b0;
    end else begin
      rbin    <= rbin_nxt;
      rgray   <= rbin_nxt ^ (rbin_nxt >> 1);
      if (advance) rd_data <= mem_q;
      empty   <= empty_nxt;
      aempty  <= aempty_nxt;
      rd_err  <= rd_en & empty;
    end
  end
endmodule

// File: rtl/dcfifo_flags.sv
`timescale 1ns/100ps
module dcfifo_flags import dcf_pkg::*; #(
  parameter int       DATA_W    = 8,
  parameter int       ADDR_W    = 4,
  parameter int       AE_LEVEL  = 2,
  parameter int       AF_LEVEL  = 2,
  parameter rd_mode_e READ_MODE = RD_STANDARD
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              arst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_afull,
  output logic              wr_err,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              rd_aempty,
  output logic              rd_err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  // Named internal events, observed by the bound checker.
  logic [PW-1:0]     wptr_gray, rptr_gray, wptr_gray_rd, rptr_gray_wr;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wr_go, rd_take;
  ptr_t              wr_level;
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] store [DEPTH];

  dcf_wr_side #(.ADDR_W(ADDR_W), .AF_LEVEL(AF_LEVEL)) u_wr (
    .clk(wr_clk), .arst(arst), .wr_en(wr_en), .rgray_sync(rptr_gray_wr),
    .wgray(wptr_gray), .waddr(waddr), .wr_go(wr_go), .full(wr_full),
    .afull(wr_afull), .wr_err(wr_err), .level(wr_level)
  );

  dcf_sync2 #(.W(PW)) u_w2r (.clk(rd_clk), .arst(arst), .d(wptr_gray), .q(wptr_gray_rd));
  dcf_sync2 #(.W(PW)) u_r2w (.clk(wr_clk), .arst(arst), .d(rptr_gray), .q(rptr_gray_wr));

  dcf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .AE_LEVEL(AE_LEVEL),
                .READ_MODE(READ_MODE)) u_rd (
    .clk(rd_clk), .arst(arst), .rd_en(rd_en), .wgray_sync(wptr_gray_rd),
    .mem_q(mem_q), .rgray(rptr_gray), .raddr(raddr), .rd_take(rd_take),
    .rd_data(rd_data), .empty(rd_empty), .aempty(rd_aempty), .rd_err(rd_err)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_go) store[waddr] <= wr_data;
  end

  assign mem_q = store[raddr];
endmodule

// File: rtl/dcf_checker.sv
`timescale 1ns/100ps
module dcf_checker import dcf_pkg::*; #(
  parameter int       DATA_W    = 8,
  parameter int       ADDR_W    = 4,
  parameter rd_mode_e READ_MODE = RD_STANDARD
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              arst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              wr_full,
  input logic              wr_afull,
  input logic              wr_err,
  input logic              rd_empty,
  input logic              rd_aempty,
  input logic              rd_err,
  input logic              rd_take,
  input logic [ADDR_W:0]   wptr_gray,
  input logic [ADDR_W:0]   rptr_gray,
  input logic [DATA_W-1:0] rd_data,
  input ptr_t              wr_level
);
  localparam int DEPTH = 1 << ADDR_W;

  assert_wr_gray_step_R11: assert property (@(posedge wr_clk) disable iff (arst)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  assert_rd_gray_step_R11: assert property (@(posedge rd_clk) disable iff (arst)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1);

  assert_no_overflow_R6: assert property (@(posedge wr_clk) disable iff (arst)
    wr_level <= ptr_t'(DEPTH));

  assert_full_has_afull_R6: assert property (@(posedge wr_clk) disable iff (arst)
    wr_full |-> wr_afull);

  assert_empty_has_aempty_R5: assert property (@(posedge rd_clk) disable iff (arst)
    rd_empty |-> rd_aempty);

  assert_wr_refused_R7: assert property (@(posedge wr_clk) disable iff (arst)
    (wr_full && wr_en) |=> (wr_err && wptr_gray == $past(wptr_gray)));

  assert_rd_refused_R8: assert property (@(posedge rd_clk) disable iff (arst)
    (rd_empty && rd_en) |=> (rd_err && !$past(rd_take)));

  generate
    if (READ_MODE == RD_STANDARD) begin : g_reg_checks
      assert_rd_hold_R8: assert property (@(posedge rd_clk) disable iff (arst)
        (rd_empty && rd_en) |=> ($stable(rd_data) && $stable(rptr_gray)));
    end
  endgenerate
endmodule

bind dcfifo_flags dcf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .READ_MODE(READ_MODE)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .arst(arst), .wr_en(wr_en), .rd_en(rd_en),
  .wr_full(wr_full), .wr_afull(wr_afull), .wr_err(wr_err), .rd_empty(rd_empty),
  .rd_aempty(rd_aempty), .rd_err(rd_err), .rd_take(rd_take), .wptr_gray(wptr_gray),
  .rptr_gray(rptr_gray), .rd_data(rd_data), .wr_level(wr_level)
);

// File: tb/dcfifo_flags_test.sv
`timescale 1ns/100ps
module dcfifo_flags_test;
  import dcf_pkg::*;

  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int AE = 2;
  localparam int AF = 2;

  logic wclk = 1'b0, rclk = 1'b0, arst = 1'b1;
  logic [1:0] wen = '0, ren = '0;
  logic [DW-1:0] wdat = '0;
  logic [1:0] full_v, afull_v, werr_v, empty_v, aempty_v, rerr_v;
  logic [DW-1:0] rdat_v [2];

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2 wclk = ~wclk;                 // 250 MHz write clock
  initial begin #1; forever #3.5 rclk = ~rclk; end

  dcfifo_flags #(.DATA_W(DW), .ADDR_W(AW), .AE_LEVEL(AE), .AF_LEVEL(AF),
                 .READ_MODE(RD_STANDARD)) uut (
    .wr_clk(wclk), .rd_clk(rclk), .arst(arst), .wr_en(wen[0]), .wr_data(wdat),
    .wr_full(full_v[0]), .wr_afull(afull_v[0]), .wr_err(werr_v[0]), .rd_en(ren[0]),
    .rd_data(rdat_v[0]), .rd_empty(empty_v[0]), .rd_aempty(aempty_v[0]), .rd_err(rerr_v[0]));

  dcfifo_flags #(.DATA_W(DW), .ADDR_W(AW), .AE_LEVEL(AE), .AF_LEVEL(AF),
                 .READ_MODE(RD_FWFT)) uut_la (
    .wr_clk(wclk), .rd_clk(rclk), .arst(arst), .wr_en(wen[1]), .wr_data(wdat),
    .wr_full(full_v[1]), .wr_afull(afull_v[1]), .wr_err(werr_v[1]), .rd_en(ren[1]),
    .rd_data(rdat_v[1]), .rd_empty(empty_v[1]), .rd_aempty(aempty_v[1]), .rd_err(rerr_v[1]));

  logic [DW-1:0] q[$];

  function automatic logic [DW-1:0] pat(int i, int s);
    int v;
    v = i * 29 + s * 53 + 11;
    return v[DW-1:0];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge rclk);
    repeat (5) @(negedge wclk);
  endtask

  task automatic wr1(int m, logic [DW-1:0] d);
    @(negedge wclk); wen[m] = 1'b1; wdat = d;
    @(negedge wclk); wen[m] = 1'b0;
  endtask

  task automatic rd1(int m);
    @(negedge rclk); ren[m] = 1'b1;
    @(negedge rclk); ren[m] = 1'b0;
  endtask

  // Flags expected once both sides are quiet, from the bench's own count.
  task automatic check_settled(int m, int held, string tag);
    int stored;
    stored = held - ((m == 1 && held > 0) ? 1 : 0);
    chk({tag, " R6 full"},    int'(full_v[m]),   int'(stored == DEPTH));
    chk({tag, " R6 afull"},   int'(afull_v[m]),  int'(stored >= DEPTH - AF));
    chk({tag, " R5 aempty"},  int'(aempty_v[m]), int'(held <= AE));
    chk({tag, " R4 empty"},   int'(empty_v[m]),  int'(held == 0));
  endtask

  task automatic run_mode(int m);
    int cap;
    logic [DW-1:0] x, last;
    cap = DEPTH + m;

    // R8: read of an empty FIFO
    rd1(m);
    chk("R8 rd_err pulse", int'(rerr_v[m]), 1);
    chk("R8 still empty", int'(empty_v[m]), 1);
    chk("R8 data untouched", int'(rdat_v[m]), 0);
    @(negedge rclk);
    chk("R8 rd_err one cycle", int'(rerr_v[m]), 0);

    // Fill one word at a time
    for (int i = 0; i < cap; i++) begin
      wr1(m, pat(i, m));
      q.push_back(pat(i, m));
      settle();
      check_settled(m, i + 1, "fill");
      if (m == 1) chk("R3 head shown early", int'(rdat_v[m]), int'(q[0]));
    end

    // R7: overflow attempt
    wr1(m, 8'hEE);
    chk("R7 wr_err pulse", int'(werr_v[m]), 1);
    @(negedge wclk);
    chk("R7 wr_err one cycle", int'(werr_v[m]), 0);
    chk("R7 still full", int'(full_v[m]), 1);

    // Drain one word at a time
    last = '0;
    while (q.size() > 0) begin
      if (m == 0) begin
        rd1(m);
        last = q.pop_front();
        chk("R2 data after edge", int'(rdat_v[m]), int'(last));
        chk("R4 empty at last word", int'(empty_v[m]), int'(q.size() == 0));
        chk("R5 aempty same edge", int'(aempty_v[m]), int'(q.size() <= AE));
      end else begin
        chk("R3 head before read", int'(rdat_v[m]), int'(q[0]));
        chk("R3 not empty", int'(empty_v[m]), 0);
        rd1(m);
        last = q.pop_front();
        settle();
        if (q.size() > 0) chk("R3 next head", int'(rdat_v[m]), int'(q[0]));
      end
      settle();
      check_settled(m, q.size(), "drain");
    end

    // R8: read after drain keeps the last word in registered mode
    rd1(m);
    chk("R8 rd_err after drain", int'(rerr_v[m]), 1);
    if (m == 0) chk("R8 data held", int'(rdat_v[m]), int'(last));

    // R9: write then an immediate read into an empty FIFO
    x = pat(100, m);
    @(negedge wclk); wen[m] = 1'b1; wdat = x;
    @(posedge wclk);
    fork begin #1 wen[m] = 1'b0; end join_none
    @(negedge rclk); ren[m] = 1'b1;
    @(negedge rclk); ren[m] = 1'b0;
    chk("R9 read refused", int'(rerr_v[m]), 1);
    chk("R9 empty held", int'(empty_v[m]), 1);
    settle();
    if (m == 0) begin
      rd1(m);
      chk("R9 word delivered later", int'(rdat_v[m]), int'(x));
    end else begin
      chk("R9 word delivered later", int'(rdat_v[m]), int'(x));
      rd1(m);
    end
    settle();
    chk("R9 empty again", int'(empty_v[m]), 1);

    // R10: crossing latency, counted in read-clock edges
    begin
      int edges;
      x = pat(200, m);
      @(negedge wclk); wen[m] = 1'b1; wdat = x;
      @(posedge wclk);
      fork begin #1 wen[m] = 1'b0; end join_none
      edges = 0;
      for (int k = 0; k < 10; k++) begin
        @(posedge rclk); edges++;
        @(negedge rclk);
        if (!empty_v[m]) break;
      end
      chk("R10 empty falls on third edge", edges, 3);
      if (m == 0) rd1(m);
      chk("R10 word value", int'(rdat_v[m]), int'(x));
      if (m == 1) rd1(m);
      settle();
    end

    // R11: concurrent streaming, fast then slow reader
    for (int pace = 1; pace <= 4; pace += 3) begin
      int total;
      total = 4 * DEPTH + 3;
      fork
        begin
          int wi;
          wi = 0;
          while (wi < total) begin
            @(negedge wclk);
            if (!full_v[m]) begin wen[m] = 1'b1; wdat = pat(wi, 7 + pace); wi++; end
            else wen[m] = 1'b0;
          end
          @(negedge wclk); wen[m] = 1'b0;
        end
        begin
          int ri, cyc;
          bit pend;
          ri = 0; cyc = 0; pend = 0;
          while (ri < total) begin
            bit go;
            @(negedge rclk);
            cyc++;
            if (m == 0) begin
              if (pend) begin
                chk("R11 order", int'(rdat_v[m]), int'(pat(ri, 7 + pace))); ri++;
              end
              go = !empty_v[m] && (cyc % pace == 0) && (ri < total);
              pend = go;
            end else begin
              go = !empty_v[m] && (cyc % pace == 0);
              if (go) begin
                chk("R11 order", int'(rdat_v[m]), int'(pat(ri, 7 + pace))); ri++;
              end
            end
            ren[m] = go;
          end
          @(negedge rclk); ren[m] = 1'b0;
        end
      join
      settle();
      check_settled(m, 0, "R11 after stream");
    end
  endtask

  initial begin
    #10;
    for (int m = 0; m < 2; m++) begin
      chk("R1 empty", int'(empty_v[m]), 1);
      chk("R1 aempty", int'(aempty_v[m]), 1);
      chk("R1 full", int'(full_v[m]), 0);
      chk("R1 afull", int'(afull_v[m]), 0);
      chk("R1 errs", int'({werr_v[m], rerr_v[m]}), 0);
      chk("R1 data", int'(rdat_v[m]), 0);
    end
    #10 arst = 1'b0;
    settle();
    for (int m = 0; m < 2; m++) begin
      run_mode(m);
      settle();
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #700000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule